// File: doc/BRIEF.md
# Power-Managed Successive-Approximation Conversion Sequencer

This block is the digital control core of an 8-bit successive-approximation converter. It runs in the system clock domain and takes one asynchronous start strobe from the host. A rising strobe edge wakes the analog section and times its power-up interval. A falling edge puts the track/hold into hold and starts the binary search. The search drives a trial code to an external DAC and reads back one comparator bit per step. The analog comparator, DAC and sampling capacitor sit outside the block.

When the search ends, the block samples the strobe level. A high strobe keeps the converter powered for back-to-back conversions. A low strobe turns the converter off after the result leaves. The result goes to the serial output stage over a valid/ready link. `res_valid_o` rises with `res_data_o` and both hold steady until `res_ready_i` is seen high on a clock edge. That edge is the latch strobe. The serial stage holds `res_ready_i` low while it is still shifting out a previous result, and the latch then waits. After a result is taken in powered mode, the block tracks for an acquisition window before it will hold again. A falling strobe edge that arrives during power-up, during the acquisition window or while a result waits is remembered, and it starts the conversion as soon as it is allowed.

Top module: `sar_pd_seq`

## Requirements
- R1: After reset, `pwr_en_o`, `hold_o`, `busy_o` and `res_valid_o` are all 0, and the converter stays powered down.
- R2: A rising strobe edge while powered down sets `pwr_en_o` to 1 within 4 clocks. No conversion starts until PWRUP_CYCLES clocks of power have passed, and none starts unless the strobe has fallen.
- R3: A falling strobe edge while powered and idle sets `hold_o` and `busy_o` to 1 within 3 clocks.
- R4: A falling strobe edge during power-up sets `busy_o` at once, but `hold_o` stays 0 until the power-up interval ends. The conversion then starts with no further strobe edge.
- R5: A conversion sets trial bits from the MSB down, so the first code driven is 8'h80. Each trial lasts SETTLE_CYCLES+1 clocks, so `hold_o` is high for 8*(SETTLE_CYCLES+1) clocks. A comparator input of 1 means the input is at or above the trial code. The result is the straight-binary code, equal to the largest code the input reaches.
- R6: The strobe level sampled at the end of the search picks the next mode. If it is low, `pwr_en_o` goes to 0 once the result is taken. If it is high, `pwr_en_o` stays 1.
- R7: `res_valid_o` and `res_data_o` hold steady while `res_ready_i` is 0. The converter stays powered and `busy_o` stays 1 until the result is taken.
- R8: `hold_o` is 0 whenever `res_valid_o` is 1. In powered mode, a falling strobe edge that arrives in the result cycle or during the acquisition window is deferred. Hold then rises ACQ_CYCLES clocks after the result is taken.
- R9: If the strobe rises while a result waits and power-down was chosen, the block power-cycles. `pwr_en_o` stays 1, and a new power-up interval is timed.
- R10: Strobe edges during a conversion are ignored, and so are rising edges while powered. Each conversion gives exactly one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_strobe_i | input | 1 | Asynchronous start/power strobe from the host |
| cmp_i | input | 1 | Comparator bit: 1 when the held input is at or above the trial code |
| dac_code_o | output | RES_BITS | Trial code sent to the DAC |
| hold_o | output | 1 | Track/hold select: 1 = hold (converting), 0 = track |
| pwr_en_o | output | 1 | Analog power enable |
| busy_o | output | 1 | High from an accepted falling strobe edge until the result is latched |
| res_valid_o | output | 1 | Result offered to the serial stage |
| res_ready_i | input | 1 | Serial stage free; valid and ready together latch the result |
| res_data_o | output | RES_BITS | Conversion result |

## Verification
The most delicate overlap is the handoff of a finished result landing in the same cycle as a new strobe edge. One case is a falling edge while the result is taken in powered mode. The other is a rising edge while a result waits under back-pressure after power-down was chosen. The bench drops the strobe in the very cycle the result is accepted, then counts clocks until hold rises and expects the acquisition window to be honoured exactly once. It also raises the strobe while ready is held low and checks that power never drops and that a fresh power-up interval delays the next hold. A third overlap is the end of power-up meeting an early falling edge. This is judged by the number of clocks from that edge to hold.

// File: rtl/sar_pd_seq_pkg.sv
package sar_pd_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_WAKE  = 3'd1,
    ST_READY = 3'd2,
    ST_CONV  = 3'd3,
    ST_HAND  = 3'd4,
    ST_ACQ   = 3'd5
  } seq_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic             done_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int RES_BITS      = 8,
  parameter int SETTLE_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] trial_o,
  output logic                done_o,
  output logic [RES_BITS-1:0] result_o
);
  localparam int IW = (RES_BITS < 2) ? 1 : $clog2(RES_BITS);
  localparam int CW = (SETTLE_CYCLES < 1) ? 1 : $clog2(SETTLE_CYCLES + 1);
  localparam logic [RES_BITS-1:0] ONE   = {{(RES_BITS-1){1'b0}}, 1'b1};
  localparam logic [RES_BITS-1:0] TOPB  = ONE << (RES_BITS - 1);
  localparam logic [CW-1:0]       SETTLE = CW'(SETTLE_CYCLES);

  logic                active_q;
  logic [IW-1:0]       idx_q;
  logic [CW-1:0]       wait_q;
  logic [RES_BITS-1:0] trial_q;
  logic [RES_BITS-1:0] bit_mask;
  logic [RES_BITS-1:0] kept;
  logic                decide;

  always_comb begin
    bit_mask = ONE << idx_q;
    decide   = active_q && (wait_q == '0);
    kept     = cmp_i ? trial_q : (trial_q & ~bit_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      wait_q   <= '0;
      trial_q  <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= IW'(RES_BITS - 1);
      wait_q   <= SETTLE;
      trial_q  <= TOPB;
    end else if (decide) begin
      if (idx_q == '0) begin
        trial_q  <= kept;
        active_q <= 1'b0;
      end else begin
        trial_q <= kept | (bit_mask >> 1);
        idx_q   <= idx_q - 1'b1;
        wait_q  <= SETTLE;
      end
    end else if (active_q) begin
      wait_q <= wait_q - 1'b1;
    end
  end

  assign trial_o  = trial_q;
  assign done_o   = decide && (idx_q == '0);
  assign result_o = kept;
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import sar_pd_seq_pkg::*;
#(
  parameter int RES_BITS     = 8,
  parameter int TW           = 8,
  parameter int PWRUP_CYCLES = 150,
  parameter int ACQ_CYCLES   = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic                level_i,
  input  logic                tmr_done_i,
  input  logic                eng_done_i,
  input  logic [RES_BITS-1:0] eng_result_i,
  input  logic                res_ready_i,
  output logic                tmr_load_o,
  output logic [TW-1:0]       tmr_val_o,
  output logic                eng_start_o,
  output logic                hold_o,
  output logic                pwr_en_o,
  output logic                busy_o,
  output logic                res_valid_o,
  output logic [RES_BITS-1:0] res_data_o
);
  localparam logic [TW-1:0] WAKE_VAL = TW'(PWRUP_CYCLES - 1);
  localparam logic [TW-1:0] ACQ_VAL  = TW'(ACQ_CYCLES - 1);

  seq_state_t          state_q, state_d;
  logic                pend_q;
  logic                keep_q;
  logic                rise_seen_q;
  logic [RES_BITS-1:0] data_q;
  logic                take;

  assign take = (state_q == ST_HAND) && res_ready_i;

  always_comb begin
    state_d     = state_q;
    tmr_load_o  = 1'b0;
    tmr_val_o   = WAKE_VAL;
    eng_start_o = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        if (rise_i) begin
          state_d    = ST_WAKE;
          tmr_load_o = 1'b1;
        end
      end
      ST_WAKE, ST_ACQ: begin
        if (tmr_done_i) begin
          if (pend_q || fall_i) begin
            state_d     = ST_CONV;
            eng_start_o = 1'b1;
          end else begin
            state_d = ST_READY;
          end
        end
      end
      ST_READY: begin
        if (fall_i) begin
          state_d     = ST_CONV;
          eng_start_o = 1'b1;
        end
      end
      ST_CONV: begin
        if (eng_done_i) state_d = ST_HAND;
      end
      ST_HAND: begin
        if (res_ready_i) begin
          if (keep_q) begin
            state_d    = ST_ACQ;
            tmr_load_o = 1'b1;
            tmr_val_o  = ACQ_VAL;
          end else if (rise_seen_q || rise_i) begin
            state_d    = ST_WAKE;
            tmr_load_o = 1'b1;
          end else begin
            state_d = ST_OFF;
          end
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_OFF;
      pend_q      <= 1'b0;
      keep_q      <= 1'b0;
      rise_seen_q <= 1'b0;
      data_q      <= '0;
    end else begin
      state_q <= state_d;
      if (eng_start_o || state_d == ST_OFF) begin
        pend_q <= 1'b0;
      end else if (fall_i && (state_q == ST_WAKE || state_q == ST_ACQ ||
                              state_q == ST_HAND)) begin
        pend_q <= 1'b1;
      end
      if (state_q == ST_CONV && eng_done_i) begin
        keep_q <= level_i;
        data_q <= eng_result_i;
      end
      if (state_q == ST_CONV) begin
        rise_seen_q <= 1'b0;
      end else if (state_q == ST_HAND && rise_i) begin
        rise_seen_q <= 1'b1;
      end
    end
  end

  assign hold_o      = (state_q == ST_CONV);
  assign pwr_en_o    = (state_q != ST_OFF);
  assign busy_o      = pend_q || (state_q == ST_CONV) || (state_q == ST_HAND && !take)
                       || (state_q == ST_HAND && take && pend_q);
  assign res_valid_o = (state_q == ST_HAND);
  assign res_data_o  = data_q;
endmodule

// File: rtl/sar_pd_seq.sv
module sar_pd_seq
  import sar_pd_seq_pkg::*;
#(
  parameter int RES_BITS      = 8,
  parameter int PWRUP_CYCLES  = 150,
  parameter int SETTLE_CYCLES = 2,
  parameter int ACQ_CYCLES    = 10,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_strobe_i,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic                hold_o,
  output logic                pwr_en_o,
  output logic                busy_o,
  output logic                res_valid_o,
  input  logic                res_ready_i,
  output logic [RES_BITS-1:0] res_data_o
);
  localparam int TMAX = max2(PWRUP_CYCLES, ACQ_CYCLES);
  localparam int TW   = (TMAX < 2) ? 1 : $clog2(TMAX);

  logic                lvl, rise, fall;
  logic                tmr_load, tmr_done;
  logic [TW-1:0]       tmr_val;
  logic                eng_start, eng_done;
  logic [RES_BITS-1:0] eng_result;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(start_strobe_i),
    .level_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  seq_timer #(.WIDTH(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
    .load_val_i(tmr_val), .done_o(tmr_done)
  );

  sar_search #(.RES_BITS(RES_BITS), .SETTLE_CYCLES(SETTLE_CYCLES)) u_search (
    .clk(clk), .rst_n(rst_n), .start_i(eng_start), .cmp_i(cmp_i),
    .trial_o(dac_code_o), .done_o(eng_done), .result_o(eng_result)
  );

  seq_ctrl #(
    .RES_BITS(RES_BITS), .TW(TW),
    .PWRUP_CYCLES(PWRUP_CYCLES), .ACQ_CYCLES(ACQ_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rise_i(rise), .fall_i(fall), .level_i(lvl),
    .tmr_done_i(tmr_done), .eng_done_i(eng_done), .eng_result_i(eng_result),
    .res_ready_i(res_ready_i),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .eng_start_o(eng_start),
    .hold_o(hold_o), .pwr_en_o(pwr_en_o), .busy_o(busy_o),
    .res_valid_o(res_valid_o), .res_data_o(res_data_o)
  );
endmodule

// File: rtl/sar_pd_seq_chk.sv
module sar_pd_seq_chk #(
  parameter int RES_BITS     = 8,
  parameter int PWRUP_CYCLES = 150
) (
  input logic                clk,
  input logic                rst_n,
  input logic [RES_BITS-1:0] dac_code_o,
  input logic                hold_o,
  input logic                pwr_en_o,
  input logic                busy_o,
  input logic                res_valid_o,
  input logic                res_ready_i,
  input logic [RES_BITS-1:0] res_data_o
);
  localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

  int unsigned on_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_cnt <= 0;
    end else if (!pwr_en_o) begin
      on_cnt <= 0;
    end else if (on_cnt < PWRUP_CYCLES) begin
      on_cnt <= on_cnt + 1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!pwr_en_o && !hold_o && !busy_o && !res_valid_o)
        else $error("outputs active during reset");
    end
  end

  assert_powerup_timed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> (on_cnt >= PWRUP_CYCLES));

  assert_hold_powered_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> pwr_en_o);

  assert_hold_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> busy_o);

  assert_msb_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> (dac_code_o == MSB_ONLY));

  assert_result_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o) && pwr_en_o));

  assert_track_on_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> !hold_o);
endmodule

bind sar_pd_seq sar_pd_seq_chk #(.RES_BITS(RES_BITS), .PWRUP_CYCLES(PWRUP_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .dac_code_o(dac_code_o), .hold_o(hold_o),
  .pwr_en_o(pwr_en_o), .busy_o(busy_o), .res_valid_o(res_valid_o),
  .res_ready_i(res_ready_i), .res_data_o(res_data_o)
);

// File: tb/sar_pd_seq_tb_top.sv
module sar_pd_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RB = 8;
  localparam int P  = 20;
  localparam int S  = 1;
  localparam int A  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strobe = 1'b0;
  logic          ready = 1'b1;
  logic [RB-1:0] ain = '0;
  logic [RB-1:0] dac;
  logic          cmp, hold, pwr, busy, valid;
  logic [RB-1:0] rdata;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  assign cmp = (ain >= dac);

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_pd_seq #(
    .RES_BITS(RB), .PWRUP_CYCLES(P), .SETTLE_CYCLES(S),
    .ACQ_CYCLES(A), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_strobe_i(strobe), .cmp_i(cmp),
    .dac_code_o(dac), .hold_o(hold), .pwr_en_o(pwr), .busy_o(busy),
    .res_valid_o(valid), .res_ready_i(ready), .res_data_o(rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_valid(input string req, output logic [RB-1:0] d);
    int n = 0;
    while (!valid && n < 500) begin
      cyc(1);
      n++;
    end
    check(valid, req, "result offered", int'(valid), 1);
    d = rdata;
  endtask

  task automatic power_idle();
    strobe = 1'b1;
    cyc(P + 6);
  endtask

  task automatic t_reset();
    check(pwr == 1'b0, "R1", "pwr_en after reset", int'(pwr), 0);
    check(hold == 1'b0 && busy == 1'b0, "R1", "hold|busy after reset", int'(hold | busy), 0);
    check(valid == 1'b0, "R1", "res_valid after reset", int'(valid), 0);
  endtask

  task automatic t_auto_pd();
    int n;
    ain = 8'hA5;
    ready = 1'b1;
    strobe = 1'b1;
    cyc(4);
    check(pwr == 1'b1, "R2", "pwr_en after rise", int'(pwr), 1);
    cyc(P + 4);
    check(hold == 1'b0, "R2", "no conversion without fall", int'(hold), 0);
    strobe = 1'b0;
    cyc(3);
    check(hold == 1'b1 && busy == 1'b1, "R3", "hold&busy after fall", int'(hold & busy), 1);
    check(dac == 8'h80, "R5", "first trial code", int'(dac), 8'h80);
    n = 1;
    forever begin
      cyc(1);
      if (hold) n++;
      else break;
    end
    check(n == 8 * (S + 1), "R5", "hold length", n, 8 * (S + 1));
    check(valid == 1'b1 && rdata == 8'hA5, "R5", "result code", int'(rdata), 8'hA5);
    check(hold == 1'b0, "R8", "track while result offered", int'(hold), 0);
    cyc(2);
    check(pwr == 1'b0, "R6", "power-down with strobe low", int'(pwr), 0);
    check(busy == 1'b0, "R7", "busy clear after latch", int'(busy), 0);
  endtask

  task automatic t_high_speed();
    logic [RB-1:0] d;
    int n;
    ain = 8'h3C;
    power_idle();
    strobe = 1'b0;
    cyc(3);
    strobe = 1'b1;
    wait_valid("R5", d);
    check(d == 8'h3C, "R5", "high-speed result", int'(d), 8'h3C);
    ain = 8'hFF;
    strobe = 1'b0;
    n = 0;
    while (!hold && n < 100) begin
      cyc(1);
      n++;
      if (n == 3) check(busy == 1'b1, "R8", "deferred fall keeps busy", int'(busy), 1);
      if (!pwr) break;
    end
    check(pwr == 1'b1, "R6", "stays powered with strobe high", int'(pwr), 1);
    check(n >= A && n <= A + 2, "R8", "acquisition window before hold", n, A + 1);
    wait_valid("R5", d);
    check(d == 8'hFF, "R5", "full-scale result", int'(d), 8'hFF);
    cyc(3);
    check(pwr == 1'b0, "R6", "power-down after low-strobe conversion", int'(pwr), 0);
  endtask

  task automatic t_early_fall();
    logic [RB-1:0] d;
    int n;
    ain = 8'h00;
    strobe = 1'b1;
    cyc(2);
    strobe = 1'b0;
    n = 0;
    while (!hold && n < 200) begin
      cyc(1);
      n++;
      if (n == 5) check(busy == 1'b1 && hold == 1'b0, "R4", "busy, not hold, in power-up",
                        int'({busy, hold}), 2);
    end
    check(n >= P && n <= P + 3, "R4", "conversion after power-up timed", n, P + 1);
    wait_valid("R5", d);
    check(d == 8'h00, "R5", "zero-scale result", int'(d), 0);
    cyc(3);
  endtask

  task automatic t_backpressure();
    logic [RB-1:0] d;
    bit ok = 1'b1;
    ain = 8'h80;
    ready = 1'b0;
    power_idle();
    strobe = 1'b0;
    wait_valid("R7", d);
    for (int i = 0; i < 12; i++) begin
      cyc(1);
      if (!(valid && rdata == d && busy && pwr)) ok = 1'b0;
    end
    check(ok, "R7", "held result, power and busy under back-pressure", int'(ok), 1);
    check(d == 8'h80, "R5", "mid-scale result", int'(d), 8'h80);
    ready = 1'b1;
    cyc(1);
    check(valid == 1'b0, "R7", "valid drops after latch", int'(valid), 0);
    cyc(1);
    check(busy == 1'b0 && pwr == 1'b0, "R7", "idle off after deferred latch", int'({busy, pwr}), 0);
  endtask

  task automatic t_rise_in_hand();
    logic [RB-1:0] d;
    bit ok = 1'b1;
    ain = 8'h7F;
    ready = 1'b0;
    power_idle();
    strobe = 1'b0;
    wait_valid("R9", d);
    strobe = 1'b1;
    cyc(4);
    ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      cyc(1);
      if (!pwr) ok = 1'b0;
    end
    check(ok, "R9", "power kept after rise in handoff", int'(ok), 1);
    cyc(P + 2);
    check(hold == 1'b0, "R9", "no hold without fall after re-power", int'(hold), 0);
    strobe = 1'b0;
    cyc(3);
    check(hold == 1'b1, "R9", "conversion after re-timed power-up", int'(hold), 1);
    wait_valid("R5", d);
    check(d == 8'h7F, "R5", "result below mid-scale", int'(d), 8'h7F);
    cyc(3);
  endtask

  task automatic t_ignore();
    logic [RB-1:0] d;
    bit ok = 1'b1;
    ain = 8'h5A;
    power_idle();
    strobe = 1'b0;
    cyc(3);
    strobe = 1'b1;
    cyc(3);
    strobe = 1'b0;
    cyc(3);
    strobe = 1'b1;
    wait_valid("R10", d);
    check(d == 8'h5A, "R10", "result unaffected by edges in conversion", int'(d), 8'h5A);
    cyc(1);
    for (int i = 0; i < A + 10; i++) begin
      cyc(1);
      if (valid || hold) ok = 1'b0;
    end
    check(ok, "R10", "single result per conversion", int'(ok), 1);
    check(pwr == 1'b1 && busy == 1'b0, "R10", "powered idle after ignored edges",
          int'({pwr, busy}), 2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_auto_pd();
    t_high_speed();
    t_early_fall();
    t_backpressure();
    t_rise_in_hand();
    t_ignore();
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule